// File: doc/BRIEF.md
# Indirect-Addressed Parallel Host Register Port

This block is an 8-bit control port through which an external microprocessor configures a bank of internal 8-bit registers. The host has a data bus, an active-low read strobe, an active-low write strobe and an address-select line. With the select line low, a write loads an address pointer. With the select line high, a write stores the bus value into the register that the pointer names. Reads follow the same rule: select low returns the pointer and select high returns the selected register. The pointer never moves on its own, so the host loads it once and can then access that register any number of times.

The strobes, the select line and the write data come from outside the clock domain. They pass through a two-flop synchroniser. A write takes effect once, when the deasserting edge of the write strobe is seen, and it uses the data and select values sampled while the strobe was still low. Read data is driven combinationally from the raw select line, the pointer and the bank. The pad's tri-state buffer is controlled through an output-enable signal. When the chip runs from its serial host interface, the serial-mode input releases the data pins: nothing is driven and no parallel access has any effect.

The register bank is presented to the rest of the chip as one flat vector. Register k sits in bits [8k+7:8k].

Top module: `host_reg_port`

## Requirements
- R1: While reset is active and after it is released, the pointer is 0, every register reads 0x00 and `bus_oe` is 0.
- R2: A write strobe pulse with `host_sel` low loads the sampled bus value into the pointer. While `host_sel` is low, `bus_out` shows the pointer.
- R3: A write strobe pulse with `host_sel` high stores the sampled bus value into register number `pointer`, which is byte `pointer` of `cfg_flat`. The store happens exactly once, within 6 clock cycles of the strobe returning high.
- R4: The pointer changes only on a pointer write. Repeated register reads and writes leave it unchanged, so it does not auto-increment.
- R5: While `host_sel` is high, `bus_out` shows the register selected by the pointer.
- R6: `bus_oe` is 1 only while `host_rd_n` is low, `host_wr_n` is high and `serial_mode` is 0. At all other times it is 0, and the bus is high impedance.
- R7: While `serial_mode` is 1, `bus_oe` stays 0, and write strobes change neither the pointer nor any register.
- R8: With the pointer at or above 12 (the number of registers), register writes are dropped and a register read returns 0x00.
- R9: A write strobe pulse during which the read strobe was also low changes nothing.
- R10: The value stored is the bus value held while the write strobe was low. A bus change made at the moment the strobe rises does not affect the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| serial_mode | input | 1 | 1 = serial host active; data pins released, parallel access disabled |
| host_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| host_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| host_sel | input | 1 | 0 = access the pointer, 1 = access the selected register |
| bus_in | input | 8 | Data bus value from the pad (host write data) |
| bus_out | output | 8 | Read data for the pad driver |
| bus_oe | output | 1 | Pad output enable for the data bus |
| cfg_flat | output | 96 | Register bank contents, register k in bits [8k+7:8k] |

## Verification
The bench first loads the pointer to the highest implemented register and then to the first unimplemented one. A design with an off-by-one limit would either corrupt a register or return stale data from the unimplemented address. Back-to-back accesses to one register show whether the design auto-increments the pointer, which would make the second access land one register further on. The bench drives both strobes low together and also pulses the write strobe in serial mode. A design missing either guard would store the bus value in those cases. The bench also flips the bus at the moment the write strobe rises, so a design that captured data late would store the inverted byte.

// File: rtl/hrp_pkg.sv
// Package: shared types for the parallel host register port.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package hrp_pkg;

    // Kind of host write that commits in the current cycle.
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_PTR  = 2'd1,
        ACC_REG  = 2'd2
    } acc_kind_e;

endpackage

// File: rtl/hrp_sync.sv
// Module: multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes: each bit is treated independently; the bundle may be skewed by
// one cycle between bits, which the access logic tolerates by only
// sampling data while the synchronised strobe is stable low.
module hrp_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First flop: samples the raw asynchronous inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= RST_VAL;
                else        stage_q[0] <= d;
            end
        end else begin : g_next
            // Later flops: resolve metastability along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/hrp_access_ctrl.sv
// Module: turns synchronised host strobes into single-cycle commit pulses.
// Captures data and select while the write strobe is low, commits on its
// rising edge, and spoils the cycle if the read strobe was also low or
// serial mode was active at any point during it.
// Assumes: inputs are already synchronised to clk.
module hrp_access_ctrl
    import hrp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_n_s,
    input  logic              wr_n_s,
    input  logic              sel_s,
    input  logic [DATA_W-1:0] data_s,
    input  logic              serial_mode,
    output acc_kind_e         kind,
    output logic [DATA_W-1:0] wdata
);

    logic              wr_prev_q;
    logic              sel_q;
    logic              spoil_q;
    logic [DATA_W-1:0] wdata_q;
    logic              wr_rise;

    assign wr_rise = wr_n_s & ~wr_prev_q;

    // Edge-detect history of the synchronised write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_prev_q <= 1'b1;
        else        wr_prev_q <= wr_n_s;
    end

    // Capture data/select while the strobe is low; track spoiled cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata_q <= '0;
            sel_q   <= 1'b0;
            spoil_q <= 1'b0;
        end else if (!wr_n_s) begin
            wdata_q <= data_s;
            sel_q   <= sel_s;
            if (!rd_n_s || serial_mode) spoil_q <= 1'b1;
        end else if (wr_rise) begin
            spoil_q <= 1'b0;
        end
    end

    // Decode the commit for the cycle in which the strobe rise is seen.
    always_comb begin
        kind = ACC_NONE;
        if (wr_rise && !spoil_q && !serial_mode) begin
            kind = sel_q ? ACC_REG : ACC_PTR;
        end
    end

    assign wdata = wdata_q;

endmodule

// File: rtl/hrp_reg_bank.sv
// Module: address pointer plus the bank of configuration registers.
// The pointer loads on pointer commits only; a register loads when a
// register commit matches its index. Pointer values with no register
// behind them match nothing, so such writes are dropped.
// Assumes: commit pulses last one cycle.
module hrp_reg_bank
    import hrp_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  acc_kind_e                  kind,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          ptr_q,
    output logic [NUM_REGS*DATA_W-1:0] cfg_flat
);

    // Address pointer: loads on a pointer commit, never increments.
    always_ff @(posedge clk) begin
        if (!rst_n)              ptr_q <= '0;
        else if (kind == ACC_PTR) ptr_q <= wdata;
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        logic [DATA_W-1:0] val_q;

        // One configuration register: loads when selected by a register commit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                val_q <= '0;
            else if (kind == ACC_REG && ptr_q == DATA_W'(r))
                val_q <= wdata;
        end

        assign cfg_flat[r*DATA_W +: DATA_W] = val_q;
    end

endmodule

// File: rtl/host_reg_port.sv
// Module: top of the indirect-addressed parallel host register port.
// Synchronises the host strobes, commits pointer/register writes, muxes
// read data and drives the pad output enable. The read path is
// combinational from the raw select and read strobe so the host sees data
// within its own read cycle.
// Assumes: serial_mode is a static, clk-domain configuration input.
module host_reg_port
    import hrp_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int NUM_REGS    = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       serial_mode,
    input  logic                       host_rd_n,
    input  logic                       host_wr_n,
    input  logic                       host_sel,
    input  logic [DATA_W-1:0]          bus_in,
    output logic [DATA_W-1:0]          bus_out,
    output logic                       bus_oe,
    output logic [NUM_REGS*DATA_W-1:0] cfg_flat
);

    localparam int SYNC_W = DATA_W + 3;

    logic [SYNC_W-1:0] raw_bundle;
    logic [SYNC_W-1:0] sync_bundle;
    acc_kind_e         kind;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] ptr_q;
    logic [DATA_W-1:0] reg_rd;

    assign raw_bundle = {host_rd_n, host_wr_n, host_sel, bus_in};

    hrp_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({2'b11, 1'b0, {DATA_W{1'b0}}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_bundle),
        .q     (sync_bundle)
    );

    hrp_access_ctrl #(
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_n_s      (sync_bundle[DATA_W+2]),
        .wr_n_s      (sync_bundle[DATA_W+1]),
        .sel_s       (sync_bundle[DATA_W]),
        .data_s      (sync_bundle[DATA_W-1:0]),
        .serial_mode (serial_mode),
        .kind        (kind),
        .wdata       (wdata)
    );

    hrp_reg_bank #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .wdata    (wdata),
        .ptr_q    (ptr_q),
        .cfg_flat (cfg_flat)
    );

    // Register read mux: unimplemented pointer values read as zero.
    always_comb begin
        reg_rd = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (ptr_q == DATA_W'(i)) reg_rd = cfg_flat[i*DATA_W +: DATA_W];
        end
    end

    // Bus data: pointer when select is low, selected register otherwise.
    always_comb begin
        bus_out = host_sel ? reg_rd : ptr_q;
    end

    // Pad enable: a clean read cycle in parallel mode only.
    always_comb begin
        bus_oe = ~host_rd_n & host_wr_n & ~serial_mode;
    end

endmodule

// File: rtl/hrp_checker.sv
// Module: property checker for host_reg_port, attached by bind below.
// Assumes: observes top ports plus the pointer and the commit decode.
module hrp_checker
    import hrp_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 12
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       serial_mode,
    input logic                       host_rd_n,
    input logic                       host_sel,
    input logic [DATA_W-1:0]          bus_out,
    input logic                       bus_oe,
    input logic [NUM_REGS*DATA_W-1:0] cfg_flat,
    input logic [DATA_W-1:0]          ptr_q,
    input acc_kind_e                  kind
);

    localparam logic [DATA_W-1:0] LIMIT = DATA_W'(NUM_REGS);

    logic [2:0] ser_cnt;

    // Counts consecutive serial-mode cycles, saturating at 4.
    always_ff @(posedge clk) begin
        if (!rst_n || !serial_mode) ser_cnt <= '0;
        else if (ser_cnt != 3'd4)   ser_cnt <= ser_cnt + 3'd1;
    end

    AST_OE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> !host_rd_n); // R6

    AST_SERIAL_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        serial_mode |-> !bus_oe); // R7

    AST_SERIAL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (serial_mode && ser_cnt == 3'd4) |=> $stable(cfg_flat) && $stable(ptr_q)); // R7

    AST_CFG_ONLY_ON_REG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != ACC_REG) |=> $stable(cfg_flat)); // R3

    AST_PTR_ONLY_ON_PTR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != ACC_PTR) |=> $stable(ptr_q)); // R4

    AST_UNIMPL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_REG && ptr_q >= LIMIT) |=> $stable(cfg_flat)); // R8

    AST_UNIMPL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel && ptr_q >= LIMIT) |-> (bus_out == '0)); // R8

    AST_PTR_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        !host_sel |-> (bus_out == ptr_q)); // R2

endmodule

bind host_reg_port hrp_checker #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .serial_mode (serial_mode),
    .host_rd_n   (host_rd_n),
    .host_sel    (host_sel),
    .bus_out     (bus_out),
    .bus_oe      (bus_oe),
    .cfg_flat    (cfg_flat),
    .ptr_q       (ptr_q),
    .kind        (kind)
);

// File: tb/tb_host_reg_port.sv
module tb_host_reg_port;

    localparam int DW = 8;
    localparam int NR = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          serial_mode = 1'b0;
    logic          host_rd_n = 1'b1;
    logic          host_wr_n = 1'b1;
    logic          host_sel = 1'b0;
    logic [DW-1:0] bus_in = '0;
    logic [DW-1:0] bus_out;
    logic          bus_oe;
    logic [NR*DW-1:0] cfg_flat;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [DW-1:0] model [NR];
    logic [DW-1:0] model_ptr;

    host_reg_port dut (
        .clk(clk), .rst_n(rst_n), .serial_mode(serial_mode),
        .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .host_sel(host_sel),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .cfg_flat(cfg_flat)
    );

    always #4 clk = ~clk;

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 100000", cycles);
            report();
        end
    end

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_cycle(input logic sel, input logic [DW-1:0] d);
        @(negedge clk);
        host_sel = sel; bus_in = d; host_wr_n = 1'b0;
        repeat (4) @(negedge clk);
        host_wr_n = 1'b1; bus_in = ~d;
        repeat (6) @(negedge clk);
    endtask

    task automatic rd_cycle(input logic sel, output logic [DW-1:0] d, output logic oe);
        @(negedge clk);
        host_sel = sel; host_rd_n = 1'b0;
        repeat (2) @(negedge clk);
        d = bus_out; oe = bus_oe;
        host_rd_n = 1'b1;
        @(negedge clk);
    endtask

    function automatic logic [DW-1:0] cfg_byte(input int k);
        return cfg_flat[k*DW +: DW];
    endfunction

    // op: 0 write ptr, 1 write reg, 2 read ptr, 3 read reg; {op, data, expected}
    localparam int NV = 22;
    localparam logic [17:0] VEC [NV] = '{
        {2'd0, 8'h03, 8'h00}, {2'd1, 8'hA5, 8'h00}, {2'd2, 8'h00, 8'h03},
        {2'd3, 8'h00, 8'hA5}, {2'd0, 8'h0B, 8'h00}, {2'd1, 8'h3C, 8'h00},
        {2'd3, 8'h00, 8'h3C}, {2'd2, 8'h00, 8'h0B}, {2'd0, 8'h03, 8'h00},
        {2'd3, 8'h00, 8'hA5}, {2'd1, 8'h5A, 8'h00}, {2'd3, 8'h00, 8'h5A},
        {2'd2, 8'h00, 8'h03}, {2'd0, 8'h00, 8'h00}, {2'd1, 8'hFF, 8'h00},
        {2'd3, 8'h00, 8'hFF}, {2'd0, 8'h0C, 8'h00}, {2'd1, 8'h77, 8'h00},
        {2'd3, 8'h00, 8'h00}, {2'd2, 8'h00, 8'h0C}, {2'd0, 8'hFF, 8'h00},
        {2'd3, 8'h00, 8'h00}
    };

    initial begin
        logic [DW-1:0] rd;
        logic          oe;
        logic [NR*DW-1:0] snap;

        for (int i = 0; i < NR; i++) model[i] = '0;
        model_ptr = '0;

        repeat (3) @(negedge clk);
        check("R1 oe during reset", bus_oe, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 bank after reset", cfg_flat, '0);
        rd_cycle(1'b0, rd, oe);
        check("R1 pointer after reset", rd, 8'h00);
        check("R6 oe idle", bus_oe, 1'b0);

        // Table walk: R2 R3 R4 R5 R8 via model
        for (int v = 0; v < NV; v++) begin
            logic [1:0]    op;
            logic [DW-1:0] dv, ev;
            op = VEC[v][17:16]; dv = VEC[v][15:8]; ev = VEC[v][7:0];
            case (op)
                2'd0: begin wr_cycle(1'b0, dv); model_ptr = dv; end
                2'd1: begin
                    wr_cycle(1'b1, dv);
                    if (model_ptr < NR) model[model_ptr] = dv;
                    check("R3 R8 stored byte", (model_ptr < NR) ? cfg_byte(int'(model_ptr)) : 8'h00,
                          (model_ptr < NR) ? dv : 8'h00);
                end
                2'd2: begin
                    rd_cycle(1'b0, rd, oe);
                    check("R2 R4 pointer read", rd, ev);
                    check("R6 oe on read", oe, 1'b1);
                end
                default: begin
                    rd_cycle(1'b1, rd, oe);
                    check("R5 R8 register read", rd, ev);
                end
            endcase
        end
        for (int i = 0; i < NR; i++) check("R8 bank matches model", cfg_byte(i), model[i]);

        // R10: bus flipped at strobe rise must not be stored
        wr_cycle(1'b0, 8'h05);
        wr_cycle(1'b1, 8'hC3);
        check("R10 data held while strobe low", cfg_byte(5), 8'hC3);

        // R8: unimplemented write leaves bank alone
        wr_cycle(1'b0, 8'h20);
        snap = cfg_flat;
        wr_cycle(1'b1, 8'h99);
        check("R8 unimplemented write dropped", cfg_flat, snap);

        // R9: both strobes low together
        wr_cycle(1'b0, 8'h01);
        @(negedge clk);
        host_sel = 1'b1; bus_in = 8'h99; host_rd_n = 1'b0; host_wr_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R6 oe with both strobes low", bus_oe, 1'b0);
        repeat (2) @(negedge clk);
        host_wr_n = 1'b1; host_rd_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R9 register unchanged", cfg_byte(1), 8'h00);
        rd_cycle(1'b0, rd, oe);
        check("R9 pointer unchanged", rd, 8'h01);

        // R7: serial mode
        serial_mode = 1'b1;
        snap = cfg_flat;
        wr_cycle(1'b1, 8'h44);
        wr_cycle(1'b0, 8'h07);
        rd_cycle(1'b1, rd, oe);
        check("R7 oe in serial mode", oe, 1'b0);
        check("R7 bank frozen", cfg_flat, snap);
        serial_mode = 1'b0;
        repeat (2) @(negedge clk);
        rd_cycle(1'b0, rd, oe);
        check("R7 pointer frozen", rd, 8'h01);

        // R1: reset in mid-run
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 bank after second reset", cfg_flat, '0);
        rd_cycle(1'b0, rd, oe);
        check("R1 pointer after second reset", rd, 8'h00);

        report();
    end

endmodule